// File: doc/BRIEF.md
# Clearable Loadable Bit-Slice Counter

This block is a binary up-counter assembled from a row of identical one-bit slices. Each slice holds one count bit. It forms two small logic functions of its stored bit and the carry arriving from the slice below. The first function gives the bit's next counting value. The second gives the fast carry that is passed up to the next slice. A two-way selector picks either the parallel load bit or the counting value. Its output then goes through an AND gate with an active-low synchronous clear before it reaches the register.

The carry into the least significant slice is the count enable. The carry that leaves the top slice is brought out as a terminal-count flag, which can enable a further counter stage. The counter counts upward only. All state changes on the rising clock edge, and the block has no asynchronous reset. The user initialises it by holding the clear low for one edge.

Top module: `clr_load_counter`

## Requirements
- R1: With `clr_n` high, `load` low and `cnt_en` high, `count` increases by one on each rising edge of `clk`, modulo 2^WIDTH.
- R2: With `clr_n` high, `load` low and `cnt_en` low, `count` keeps its value across the rising edge.
- R3: With `clr_n` low, `count` is 0 after the next rising edge, whatever `load`, `load_data` and `cnt_en` are.
- R4: With `clr_n` high and `load` high, `count` takes the value of `load_data` on the next rising edge, whether `cnt_en` is high or low.
- R5: `carry_out` is high exactly when `cnt_en` is high and every bit of `count` is 1. It follows its inputs without a clock and does not depend on `load` or `clr_n`.
- R6: When `count` is all ones and the counter is counting (`clr_n` high, `load` low, `cnt_en` high), the next value of `count` is 0.
- R7: `count` changes only at rising edges of `clk`. A change on any input between edges leaves `count` as it is until the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all updates on its rising edge |
| clr_n | input | 1 | Synchronous clear, active low, highest priority |
| load | input | 1 | Synchronous parallel load, above counting in priority |
| cnt_en | input | 1 | Count enable; carry into the least significant slice |
| load_data | input | WIDTH | Parallel value taken when loading |
| count | output | WIDTH | Present counter value |
| carry_out | output | 1 | Carry out of the top slice (terminal count while enabled) |

## Verification
The hardest case to reach from the ports is a full carry ripple while a higher-priority control fights it. This means `count` at all ones with `cnt_en` high and either `load` or `clr_n` asserted on the same edge. Counting up to that value takes 2^WIDTH cycles, so the stimulus loads all ones, and also values just below it, through `load_data`. It then combines the three controls in every way on the following edges. The random phase biases `load_data` toward all ones, so that wrap, load-over-count and clear-over-load all occur many times. The flag `carry_out` is checked between edges, after new inputs have been applied.

// File: rtl/clr_load_counter_pkg.sv
package clr_load_counter_pkg;

   localparam int unsigned MAX_WIDTH = 64;

   function automatic bit width_ok(input int unsigned w);
      return (w >= 1) && (w <= MAX_WIDTH);
   endfunction

endpackage

// File: rtl/cnt_bit_fn.sv
module cnt_bit_fn (
   input  logic q_i,
   input  logic carry_i,
   output logic next_o,
   output logic carry_o
);
   // counting value of the bit, and the fast carry to the next slice
   assign next_o  = q_i ^ carry_i;
   assign carry_o = q_i & carry_i;
endmodule

// File: rtl/cnt_slice.sv
module cnt_slice (
   input  logic clk,
   input  logic clr_n,
   input  logic load,
   input  logic load_bit,
   input  logic carry_i,
   output logic q_o,
   output logic carry_o
);
   logic q_r;
   logic cnt_val;
   logic sel_val;
   logic d_val;
   logic checks_live = 1'b0;

   cnt_bit_fn u_fn (
      .q_i    (q_r),
      .carry_i(carry_i),
      .next_o (cnt_val),
      .carry_o(carry_o)
   );

   // load selector first, then the clear gate
   assign sel_val = load ? load_bit : cnt_val;
   assign d_val   = sel_val & clr_n;

   always_ff @(posedge clk) begin
      q_r <= d_val;
   end

   assign q_o = q_r;

   always_ff @(posedge clk) begin
      checks_live <= 1'b1;
   end

   assert_clear_wins_R3: assert property (@(posedge clk) disable iff (!checks_live)
      !clr_n |=> (q_o == 1'b0));

   assert_load_bit_R4: assert property (@(posedge clk) disable iff (!checks_live)
      (clr_n && load) |=> (q_o == $past(load_bit)));

   assert_hold_R2: assert property (@(posedge clk) disable iff (!checks_live)
      (clr_n && !load && !carry_i) |=> $stable(q_o));

   assert_toggle_R1: assert property (@(posedge clk) disable iff (!checks_live)
      (clr_n && !load && carry_i) |=> (q_o != $past(q_o)));

endmodule

// File: rtl/clr_load_counter.sv
module clr_load_counter #(
   parameter int unsigned WIDTH = 8
) (
   input  logic             clk,
   input  logic             clr_n,
   input  logic             load,
   input  logic             cnt_en,
   input  logic [WIDTH-1:0] load_data,
   output logic [WIDTH-1:0] count,
   output logic             carry_out
);
   import clr_load_counter_pkg::*;

   localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};

   initial begin
      if (!width_ok(WIDTH))
         $error("clr_load_counter: WIDTH %0d outside 1..%0d", WIDTH, MAX_WIDTH);
   end

   logic [WIDTH:0] carry_chain;
   logic           checks_live = 1'b0;

   assign carry_chain[0] = cnt_en;

   for (genvar i = 0; i < WIDTH; i++) begin : g_slice
      cnt_slice u_slice (
         .clk     (clk),
         .clr_n   (clr_n),
         .load    (load),
         .load_bit(load_data[i]),
         .carry_i (carry_chain[i]),
         .q_o     (count[i]),
         .carry_o (carry_chain[i+1])
      );
   end

   assign carry_out = carry_chain[WIDTH];

   always_ff @(posedge clk) begin
      checks_live <= 1'b1;
   end

   assert_terminal_count_R5: assert property (@(posedge clk) disable iff (!checks_live)
      carry_out == (cnt_en && (count == ALL_ONES)));

   assert_wrap_R6: assert property (@(posedge clk) disable iff (!checks_live)
      (clr_n && !load && cnt_en && (count == ALL_ONES)) |=> (count == '0));

   assert_load_word_R4: assert property (@(posedge clk) disable iff (!checks_live)
      (clr_n && load) |=> (count == $past(load_data)));

endmodule

// File: tb/clr_load_counter_bench.sv
module clr_load_counter_bench;
   localparam int W = 8;
   localparam int MAXV = (1 << W) - 1;

   logic         clk = 1'b0;
   logic         clr_n = 1'b1;
   logic         load = 1'b0;
   logic         cnt_en = 1'b0;
   logic [W-1:0] load_data = '0;
   logic [W-1:0] count;
   logic         carry_out;

   int n_checks = 0;
   int n_fail = 0;
   int model = 0;
   bit model_known = 1'b0;

   always #4 clk = ~clk;

   clr_load_counter #(.WIDTH(W)) u_clr_load_counter (
      .clk(clk), .clr_n(clr_n), .load(load), .cnt_en(cnt_en),
      .load_data(load_data), .count(count), .carry_out(carry_out)
   );

   task automatic check(input string req, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   // called at a falling edge; returns at the next falling edge
   task automatic step(input bit c, input bit l, input bit e, input int d);
      string tag;
      clr_n = c; load = l; cnt_en = e; load_data = d[W-1:0];
      #1;
      if (model_known) begin
         check("R7 count steady between edges", int'(count), model);
         check("R5 carry_out", int'(carry_out), (e && model == MAXV) ? 1 : 0);
      end
      if (!c)      tag = "R3 clear";
      else if (l)  tag = "R4 load";
      else if (e)  tag = (model == MAXV) ? "R6 wrap" : "R1 increment";
      else         tag = "R2 hold";
      @(posedge clk);
      if (!c)      model = 0;
      else if (l)  model = d & MAXV;
      else if (e)  model = (model + 1) & MAXV;
      model_known = 1'b1;
      @(negedge clk);
      check(tag, int'(count), model);
   endtask

   initial begin
      @(negedge clk);
      step(0, 1, 1, 8'hA5);                 // R3 clear beats load and enable
      check("R3 reset state", int'(count), 0);
      for (int i = 0; i < 5; i++) step(1, 0, 1, 0);       // R1
      step(1, 0, 0, 8'h33); step(1, 0, 0, 0);             // R2
      step(1, 1, 0, 8'hFD);                               // R4 without enable
      step(1, 0, 1, 0); step(1, 0, 1, 0);                 // to all ones
      step(1, 0, 0, 0);                                   // R5 low with enable low
      step(1, 0, 1, 0);                                   // R6 wrap
      step(1, 1, 1, 8'hFF);                               // R4 with enable
      step(1, 1, 1, 8'h10);                               // R5 high with load, R4
      step(1, 1, 1, 8'hFF);
      step(0, 0, 1, 0);                                   // R3 over counting
      step(1, 1, 0, 8'hFF);
      step(0, 1, 1, 8'hFF);                               // R3 over load at all ones
      for (int i = 0; i < 3000; i++) begin
         int r = $urandom_range(0, 99);
         int d = ($urandom_range(0, 3) == 0) ? MAXV - int'($urandom_range(0, 2))
                                             : int'($urandom_range(0, MAXV));
         step(r >= 5, r >= 5 && r < 20, $urandom_range(0, 3) != 0, d);
      end
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      #2000000;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule